// File: doc/BRIEF.md
# Multiframe Clock Alignment Controller

This block keeps a local multiframe phase counter running in the device clock domain and pulls it into line with an external reference strobe. Every rising clock edge samples the reference. A low-to-high transition of the sampled reference marks the instant the multiframe boundary should occur. If the local counter is not already at that boundary, it is forced back to phase zero. This gives the serial link a deterministic latency that repeats across power cycles and across several devices sharing the same reference.

The reference may arrive in three forms: a free-running periodic train, one isolated pulse, or a periodic train with missing pulses. All three are handled the same way, because only the transitions matter. After each realignment, the block drops an active-low re-initialization request toward the link for a programmable number of cycles. A control-register bit gates the whole mechanism. The multiframe length, in device clock cycles, is a run-time input between 1 and 1024.

Top module: `mf_align_top`

## Requirements
- R1: The reference input is sampled only on rising clock edges. An edge is a sample of 1 that follows a sample of 0. When the reference is first sampled high at clock edge k, any realignment moves the counter to phase zero at edge k+1.
- R2: `mfLen` holds the multiframe length in cycles, as an unsigned binary value from 1 to 1024. Without realignment the phase counts up by one per cycle. It returns to zero on the cycle after it sits at `mfLen-1`, or at any higher value left over from a length change. `lmfcTick` is high exactly in the cycles where the phase is zero, so it repeats every `mfLen` cycles. With `mfLen` = 1 it stays high.
- R3: An enabled edge that arrives while the phase is not at its last value resets the phase to zero on the next cycle.
- R4: An enabled edge that arrives while the phase is at its last value leaves the counting unchanged and raises no re-initialization request.
- R5: `syncReqN` is active low. It goes low in the cycle the phase restarts after a realignment and stays low for `syncHold` cycles (1 to 255). A realignment during that window restarts the full count.
- R6: While `sysrefEn` is 0, reference edges have no effect on the phase or on `syncReqN`, and `aligned` is driven to 0 from the next cycle on.
- R7: `aligned` rises on the cycle after any enabled edge, whether or not that edge realigns. It stays high until reset or until `sysrefEn` drops.
- R8: A reference held high for many cycles counts as a single edge. Periodic, single, and gapped references therefore all realign only on their transitions.
- R9: While `rstN` is low, the phase is zero (`lmfcTick` = 1), `syncReqN` = 1 and `aligned` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sysrefIn | input | 1 | External alignment reference |
| sysrefEn | input | 1 | Control bit enabling reference processing |
| mfLen | input | LEN_W | Multiframe length in cycles (1..1024) |
| syncHold | input | HOLD_W | Cycles to hold the re-initialization request low |
| lmfcTick | output | 1 | High while the multiframe phase is zero |
| syncReqN | output | 1 | Active-low link re-initialization request |
| aligned | output | 1 | A reference edge has been processed since enable |

## Verification
The critical coincidence is a reference edge landing in the same cycle the counter would wrap on its own. Here the realignment path and the natural wrap both target phase zero, and the design must choose the wrap and stay silent on the request line. The bench provokes this with a periodic reference whose period is an exact multiple of the multiframe length, so every pulse after the first lands on the boundary. It also uses length 1, where every edge coincides with a wrap. A per-cycle reference model predicts the boundary, request and status outputs, and a scoreboard compares them cycle by cycle, so a spurious request or a phase jump shows up as a mismatch.

// File: rtl/mf_align_pkg.sv
package mf_align_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic realign;      // restart the phase and the request window
    logic markAligned;  // an enabled edge was seen
    logic clrAligned;   // processing disabled
  } mfStrobe_t;
endpackage

// File: rtl/mf_align_ctrl.sv
module mf_align_ctrl
  import mf_align_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sysrefIn,
  input  logic      sysrefEn,
  input  logic      atLast,
  output logic      edgeSeen,
  output mfStrobe_t stb
);
  logic refNow;
  logic refPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refNow  <= 1'b0;
      refPrev <= 1'b0;
    end else begin
      refNow  <= sysrefIn;
      refPrev <= refNow;
    end
  end

  assign edgeSeen = refNow & ~refPrev;

  always_comb begin
    stb.realign     = sysrefEn & edgeSeen & ~atLast;
    stb.markAligned = sysrefEn & edgeSeen;
    stb.clrAligned  = ~sysrefEn;
  end
endmodule

// File: rtl/mf_align_dp.sv
module mf_align_dp
  import mf_align_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mfStrobe_t         stb,
  input  logic [LEN_W-1:0]  mfLen,
  input  logic [HOLD_W-1:0] syncHold,
  output logic [LEN_W-1:0]  phase,
  output logic              atLast,
  output logic              lmfcTick,
  output logic              syncReqN,
  output logic              aligned
);
  localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

  logic [HOLD_W-1:0] holdLeft;

  assign atLast = (phase >= (mfLen - ONE_L));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (stb.realign || atLast) begin
      phase <= '0;
    end else begin
      phase <= phase + ONE_L;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdLeft <= '0;
    end else if (stb.realign) begin
      holdLeft <= syncHold;
    end else if (holdLeft != '0) begin
      holdLeft <= holdLeft - HOLD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aligned <= 1'b0;
    end else if (stb.clrAligned) begin
      aligned <= 1'b0;
    end else if (stb.markAligned) begin
      aligned <= 1'b1;
    end
  end

  assign lmfcTick = (phase == '0);
  assign syncReqN = (holdLeft == '0);
endmodule

// File: rtl/mf_align_top.sv
module mf_align_top
  import mf_align_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysrefIn,
  input  logic              sysrefEn,
  input  logic [LEN_W-1:0]  mfLen,
  input  logic [HOLD_W-1:0] syncHold,
  output logic              lmfcTick,
  output logic              syncReqN,
  output logic              aligned
);
  mfStrobe_t        stb;
  logic             atLast;
  logic             edgeSeen;
  logic [LEN_W-1:0] phase;

  mf_align_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sysrefIn (sysrefIn),
    .sysrefEn (sysrefEn),
    .atLast   (atLast),
    .edgeSeen (edgeSeen),
    .stb      (stb)
  );

  mf_align_dp #(.LEN_W(LEN_W), .HOLD_W(HOLD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .mfLen    (mfLen),
    .syncHold (syncHold),
    .phase    (phase),
    .atLast   (atLast),
    .lmfcTick (lmfcTick),
    .syncReqN (syncReqN),
    .aligned  (aligned)
  );
endmodule

// File: rtl/mf_align_chk.sv
module mf_align_chk
  import mf_align_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int HOLD_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sysrefEn,
  input logic [HOLD_W-1:0] syncHold,
  input mfStrobe_t         stb,
  input logic [LEN_W-1:0]  phase,
  input logic              syncReqN,
  input logic              aligned
);
  // R3
  realign_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.realign |=> (phase == '0));

  // R5
  sync_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.realign && (syncHold != '0)) |=> !syncReqN);

  // R6
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sysrefEn |=> !aligned);

  // R7
  mark_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.markAligned && sysrefEn) |=> aligned);
endmodule

bind mf_align_top mf_align_chk #(.LEN_W(LEN_W), .HOLD_W(HOLD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sysrefEn (sysrefEn),
  .syncHold (syncHold),
  .stb      (stb),
  .phase    (phase),
  .syncReqN (syncReqN),
  .aligned  (aligned)
);

// File: tb/tb_mf_align_top.sv
module tb_mf_align_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sysrefIn = 1'b0;
  logic        sysrefEn = 1'b1;
  logic [10:0] mfLen = 11'd8;
  logic [7:0]  syncHold = 8'd4;
  logic        lmfcTick, syncReqN, aligned;

  int compared = 0;
  int mismatched = 0;
  string curTag = "R9";
  logic [2:0] expQ[$];

  mf_align_top dut (
    .clk(clk), .rstN(rstN), .sysrefIn(sysrefIn), .sysrefEn(sysrefEn),
    .mfLen(mfLen), .syncHold(syncHold),
    .lmfcTick(lmfcTick), .syncReqN(syncReqN), .aligned(aligned)
  );

  always #10 clk = ~clk;

  // reference model built from the requirements; pushes expectations
  int   mCnt = 0, mHold = 0;
  logic mS1 = 1'b0, mS0 = 1'b0, mAl = 1'b0;
  always @(posedge clk) begin
    logic edgeM, lastM;
    if (!rstN) begin
      mCnt = 0; mHold = 0; mS1 = 1'b0; mS0 = 1'b0; mAl = 1'b0;
    end else begin
      edgeM = mS1 && !mS0;
      lastM = (mCnt >= int'(mfLen) - 1);
      if (sysrefEn && edgeM && !lastM) begin
        mCnt = 0; mHold = int'(syncHold);
      end else begin
        mCnt = lastM ? 0 : mCnt + 1;
        if (mHold != 0) mHold = mHold - 1;
      end
      if (!sysrefEn) mAl = 1'b0;
      else if (edgeM) mAl = 1'b1;
      mS0 = mS1; mS1 = sysrefIn;
    end
    expQ.push_back({(mCnt == 0), (mHold == 0), mAl});
  end

  task automatic cmp(string tag, string what, logic got, logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    logic [2:0] e;
    if (expQ.size() != 0) begin
      e = expQ.pop_front();
      cmp(curTag, "lmfcTick(R2)", lmfcTick, e[2]);
      cmp(curTag, "syncReqN(R5)", syncReqN, e[1]);
      cmp(curTag, "aligned(R7)", aligned, e[0]);
    end
  end

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int width);
    sysrefIn = 1'b1;
    waitN(width);
    sysrefIn = 1'b0;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R9: reset values
    waitN(4);
    cmp("R9", "reset tick", lmfcTick, 1'b1);
    cmp("R9", "reset syncReqN", syncReqN, 1'b1);
    cmp("R9", "reset aligned", aligned, 1'b0);
    rstN = 1'b1;
    curTag = "R2"; waitN(21);
    // R1, R3: single pulse off the boundary
    curTag = "R1"; waitN(2); pulse(1);
    curTag = "R3"; waitN(30);
    // R4: periodic reference, period a multiple of the length
    curTag = "R4";
    for (int i = 0; i < 5; i++) begin pulse(1); waitN(15); end
    // R8: gapped train and long-high pulse
    curTag = "R8";
    for (int i = 0; i < 6; i++) begin
      if (i != 2 && i != 3) pulse(1); else waitN(1);
      waitN(15);
    end
    waitN(3); pulse(20); waitN(25);
    // R5: realignment during the hold window restarts it
    curTag = "R5"; syncHold = 8'd6;
    waitN(5); pulse(1); waitN(2); pulse(1); waitN(20);
    // R6: disabled edges ignored
    curTag = "R6"; sysrefEn = 1'b0; waitN(3); pulse(1); waitN(5); pulse(2); waitN(20);
    // R7: re-enable, aligned returns after an edge
    curTag = "R7"; sysrefEn = 1'b1; waitN(7); pulse(1); waitN(20);
    // R2 / R4 at length 1: every edge lands on a boundary
    curTag = "R4"; mfLen = 11'd1; waitN(4); pulse(1); waitN(4); pulse(3); waitN(10);
    // R2 at maximum length
    curTag = "R2"; mfLen = 11'd1024; waitN(2100);
    pulse(1); waitN(1100);
    finishRun();
  end
endmodule